// File: doc/BRIEF.md
# Multiplexed Pixel Port Serializer

This block sits between a wide, slow pixel bus and a pixel-rate colour pipeline. On a load strobe it captures a word of up to four pixels (slots A to D). Each slot holds 8-bit red, green and blue fields, a 2-bit palette-select code, a blank bit and a sync bit. It then emits the captured pixels one per pixel clock, slot A first. The multiplex ratio is chosen at run time: 4:1 uses all four slots, 2:1 uses A and B, and 1:1 uses A alone.

The block drives a load strobe of its own, at the pixel clock divided by the active ratio. That strobe can be wired straight back to the load input. Each emitted pixel is compared against a programmed 2-bit select code. A pixel whose code does not match has its colour forced to zero and its select-valid flag cleared. Blank forces the colour to zero, the blanking level. Sync passes to the output only while the sync-enable control is set.

Top module: `pix_ser_top`

## Requirements
- R1: While reset is held, the colour outputs, `sel_valid`, `blank_out` and `sync_out` are all 0.
- R2: `load_out` is high for one clock in every M clocks, where M is taken from the active ratio: `cfg_mux` 0 gives M=1, 1 gives M=2, and 2 or 3 give M=4. It is high in the first cycle after reset.
- R3: A word is captured at every clock edge at which `load_in` is high, and emission restarts at slot A even if the previous word is only partly emitted.
- R4: Slot k of a word captured at clock edge L appears at the outputs after edge L+2+k. Slot k occupies bits [8k+7:8k] of each colour bus, bits [2k+1:2k] of `ps_in`, and bit k of `blank_in` and `sync_in`.
- R5: In 2:1 mode only slots A and B are emitted, and in 1:1 mode only slot A; the other slots never reach the outputs. Without a new load, emission repeats from slot A.
- R6: A change on `cfg_mux` takes effect only at the clock edge at which `load_out` next rises. A word is serialized at the ratio that is active when it is captured.
- R7: `sel_valid` is 1 exactly when the emitted pixel's select code equals `cfg_sel`.
- R8: A pixel whose select code does not match emits 0 on all three colour outputs.
- R9: A blanked pixel emits 0 on all colour outputs and sets `blank_out`, whatever its select match.
- R10: `sync_out` equals the pixel's sync bit ANDed with `cfg_sync_en`; when the enable is clear, sync has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mux | input | 2 | Multiplex ratio request (0: 1:1, 1: 2:1, 2/3: 4:1) |
| cfg_sel | input | 2 | Select code a pixel must carry to be shown |
| cfg_sync_en | input | 1 | Lets sync through to `sync_out` |
| load_in | input | 1 | Capture strobe, sampled at the clock edge |
| pix_r_in | input | 32 | Red fields of slots A..D |
| pix_g_in | input | 32 | Green fields of slots A..D |
| pix_b_in | input | 32 | Blue fields of slots A..D |
| ps_in | input | 8 | Select codes of slots A..D |
| blank_in | input | 4 | Blank bit per slot |
| sync_in | input | 4 | Sync bit per slot |
| load_out | output | 1 | Divided load strobe |
| pix_r | output | 8 | Serial red |
| pix_g | output | 8 | Serial green |
| pix_b | output | 8 | Serial blue |
| sel_valid | output | 1 | Emitted pixel matched `cfg_sel` |
| blank_out | output | 1 | Emitted pixel is blanked |
| sync_out | output | 1 | Gated sync of emitted pixel |

## Verification
A wrong slot index shows on the colour outputs two clocks after the slot should have been chosen, as a pixel from another slot or a stale word. It is caught in the first cycle of the faulty emission. A wrong divider count or a ratio change at the wrong time moves `load_out` off its expected cycle within one load period, at most four clocks. After that, every later word is serialized at the wrong length, so the error persists. Faults in the select compare or in the blank and sync gating change the outputs of the very pixel they affect, and the bench sweeps every select code against every programmed code.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;

    localparam int CH_W   = 8;
    localparam int PS_W   = 2;
    localparam int SLOTS  = 4;
    localparam int MODE_W = 2;
    localparam int IDX_W  = $clog2(SLOTS);

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
        logic [PS_W-1:0] ps;
        logic            blank;
        logic            sync;
    } pix_t;

    typedef enum logic [MODE_W-1:0] {
        MUX_1  = 2'd0,
        MUX_2  = 2'd1,
        MUX_4  = 2'd2,
        MUX_4B = 2'd3
    } mux_e;

    // Index of the last slot emitted for a given ratio.
    function automatic logic [IDX_W-1:0] last_of(mux_e m);
        case (m)
            MUX_1:   return '0;
            MUX_2:   return IDX_W'(1);
            default: return IDX_W'(SLOTS - 1);
        endcase
    endfunction

endpackage

// File: rtl/pix_ser_loadgen.sv
module pix_ser_loadgen
    import pix_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] cfg_mux,
    output mux_e              act_mode,
    output logic              load_out
);

    logic [IDX_W-1:0] div_cnt;

    // The ratio request is adopted only when the divider wraps.
    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt  <= '0;
            act_mode <= mux_e'(cfg_mux);
        end else if (div_cnt == last_of(act_mode)) begin
            div_cnt  <= '0;
            act_mode <= mux_e'(cfg_mux);
        end else begin
            div_cnt  <= div_cnt + 1'b1;
        end
    end

    assign load_out = (div_cnt == '0);

endmodule

// File: rtl/pix_ser_capture.sv
module pix_ser_capture
    import pix_ser_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_in,
    input  mux_e                  act_mode,
    input  logic [SLOTS*CH_W-1:0] pix_r_in,
    input  logic [SLOTS*CH_W-1:0] pix_g_in,
    input  logic [SLOTS*CH_W-1:0] pix_b_in,
    input  logic [SLOTS*PS_W-1:0] ps_in,
    input  logic [SLOTS-1:0]      blank_in,
    input  logic [SLOTS-1:0]      sync_in,
    output mux_e                  cap_mode,
    output logic [IDX_W-1:0]      slot_idx,
    output pix_t                  st1
);

    pix_t slot_in [SLOTS];
    pix_t cap_q   [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_in[s] = '{
            r:     pix_r_in[s*CH_W +: CH_W],
            g:     pix_g_in[s*CH_W +: CH_W],
            b:     pix_b_in[s*CH_W +: CH_W],
            ps:    ps_in[s*PS_W +: PS_W],
            blank: blank_in[s],
            sync:  sync_in[s]
        };
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SLOTS; s++) cap_q[s] <= '0;
            cap_mode <= MUX_1;
            slot_idx <= '0;
            st1      <= '0;
        end else begin
            // First pipeline register: slot selection.
            st1 <= cap_q[slot_idx];
            if (load_in) begin
                for (int s = 0; s < SLOTS; s++) cap_q[s] <= slot_in[s];
                cap_mode <= act_mode;
                slot_idx <= '0;
            end else if (slot_idx == last_of(cap_mode)) begin
                slot_idx <= '0;
            end else begin
                slot_idx <= slot_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pix_ser_gate.sv
module pix_ser_gate
    import pix_ser_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  pix_t            st1,
    input  logic [PS_W-1:0] cfg_sel,
    input  logic            cfg_sync_en,
    output logic [CH_W-1:0] pix_r,
    output logic [CH_W-1:0] pix_g,
    output logic [CH_W-1:0] pix_b,
    output logic            sel_valid,
    output logic            blank_out,
    output logic            sync_out
);

    logic hit;
    logic show;

    always_comb begin
        hit  = (st1.ps == cfg_sel);
        show = hit && !st1.blank;
    end

    // Second pipeline register: palette match and video gating.
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_r     <= '0;
            pix_g     <= '0;
            pix_b     <= '0;
            sel_valid <= 1'b0;
            blank_out <= 1'b0;
            sync_out  <= 1'b0;
        end else begin
            pix_r     <= show ? st1.r : '0;
            pix_g     <= show ? st1.g : '0;
            pix_b     <= show ? st1.b : '0;
            sel_valid <= hit;
            blank_out <= st1.blank;
            sync_out  <= st1.sync & cfg_sync_en;
        end
    end

endmodule

// File: rtl/pix_ser_top.sv
module pix_ser_top
    import pix_ser_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [MODE_W-1:0]     cfg_mux,
    input  logic [PS_W-1:0]       cfg_sel,
    input  logic                  cfg_sync_en,
    input  logic                  load_in,
    input  logic [SLOTS*CH_W-1:0] pix_r_in,
    input  logic [SLOTS*CH_W-1:0] pix_g_in,
    input  logic [SLOTS*CH_W-1:0] pix_b_in,
    input  logic [SLOTS*PS_W-1:0] ps_in,
    input  logic [SLOTS-1:0]      blank_in,
    input  logic [SLOTS-1:0]      sync_in,
    output logic                  load_out,
    output logic [CH_W-1:0]       pix_r,
    output logic [CH_W-1:0]       pix_g,
    output logic [CH_W-1:0]       pix_b,
    output logic                  sel_valid,
    output logic                  blank_out,
    output logic                  sync_out
);

    mux_e             act_mode;
    mux_e             cap_mode;
    logic [IDX_W-1:0] slot_idx;
    pix_t             st1;

    pix_ser_loadgen i_loadgen (
        .clk      (clk),
        .rst      (rst),
        .cfg_mux  (cfg_mux),
        .act_mode (act_mode),
        .load_out (load_out)
    );

    pix_ser_capture i_capture (
        .clk      (clk),
        .rst      (rst),
        .load_in  (load_in),
        .act_mode (act_mode),
        .pix_r_in (pix_r_in),
        .pix_g_in (pix_g_in),
        .pix_b_in (pix_b_in),
        .ps_in    (ps_in),
        .blank_in (blank_in),
        .sync_in  (sync_in),
        .cap_mode (cap_mode),
        .slot_idx (slot_idx),
        .st1      (st1)
    );

    pix_ser_gate i_gate (
        .clk         (clk),
        .rst         (rst),
        .st1         (st1),
        .cfg_sel     (cfg_sel),
        .cfg_sync_en (cfg_sync_en),
        .pix_r       (pix_r),
        .pix_g       (pix_g),
        .pix_b       (pix_b),
        .sel_valid   (sel_valid),
        .blank_out   (blank_out),
        .sync_out    (sync_out)
    );

endmodule

// File: rtl/pix_ser_chk.sv
module pix_ser_chk
    import pix_ser_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             load_in,
    input logic             load_out,
    input logic             cfg_sync_en,
    input logic             sync_out,
    input logic             sel_valid,
    input logic             blank_out,
    input logic [CH_W-1:0]  pix_r,
    input logic [CH_W-1:0]  pix_g,
    input logic [CH_W-1:0]  pix_b,
    input mux_e             act_mode,
    input mux_e             cap_mode,
    input logic [IDX_W-1:0] slot_idx
);

    logic [2:0] gap;

    always_ff @(posedge clk) begin
        if (rst)           gap <= '0;
        else if (load_out) gap <= '0;
        else if (gap != 3'd7) gap <= gap + 3'd1;
    end

    // R2
    load_single_chk: assert property (@(posedge clk) disable iff (rst)
        (load_out && act_mode != MUX_1) |=> !load_out);

    // R2
    load_gap_chk: assert property (@(posedge clk) disable iff (rst)
        gap < 3'd4);

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        load_in |=> (slot_idx == '0));

    // R5
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_idx <= last_of(cap_mode));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_out |-> $stable(act_mode));

    // R8
    dark_unsel_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_r != '0 || pix_g != '0 || pix_b != '0) |-> sel_valid);

    // R9
    dark_blank_chk: assert property (@(posedge clk) disable iff (rst)
        blank_out |-> (pix_r == '0 && pix_g == '0 && pix_b == '0));

    // R10
    sync_gate_chk: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> $past(cfg_sync_en));

endmodule

bind pix_ser_top pix_ser_chk i_pix_ser_chk (
    .clk         (clk),
    .rst         (rst),
    .load_in     (load_in),
    .load_out    (load_out),
    .cfg_sync_en (cfg_sync_en),
    .sync_out    (sync_out),
    .sel_valid   (sel_valid),
    .blank_out   (blank_out),
    .pix_r       (pix_r),
    .pix_g       (pix_g),
    .pix_b       (pix_b),
    .act_mode    (act_mode),
    .cap_mode    (cap_mode),
    .slot_idx    (slot_idx)
);

// File: tb/test_pix_ser_top.sv
module test_pix_ser_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic [1:0]  cfg_mux, cfg_sel;
    logic        cfg_sync_en;
    logic        use_loop, man_load, man_req;
    logic        load_in_w;
    logic [31:0] pr_in, pg_in, pb_in;
    logic [7:0]  ps_in_v;
    logic [3:0]  bl_in, sy_in;
    logic        load_out, sel_valid, blank_out, sync_out;
    logic [7:0]  pix_r, pix_g, pix_b;

    assign load_in_w = use_loop ? load_out : man_load;

    pix_ser_top i_pix_ser_top (
        .clk(clk), .rst(rst), .cfg_mux(cfg_mux), .cfg_sel(cfg_sel),
        .cfg_sync_en(cfg_sync_en), .load_in(load_in_w),
        .pix_r_in(pr_in), .pix_g_in(pg_in), .pix_b_in(pb_in),
        .ps_in(ps_in_v), .blank_in(bl_in), .sync_in(sy_in),
        .load_out(load_out), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .sel_valid(sel_valid), .blank_out(blank_out), .sync_out(sync_out)
    );

    int n_cmp = 0, n_bad = 0, tcyc = 0, nload = 0, m_cnt = 0;
    logic [1:0] m_act, nx_mux, nx_sel;
    logic       nx_sync, done;

    logic [7:0] e_r [16], e_g [16], e_b [16];
    logic [1:0] e_ps [16];
    logic       e_bl [16], e_sy [16], e_v [16];

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, tcyc);
        end
    endtask

    function automatic int nslots(logic [1:0] m);
        return (m == 2'd0) ? 1 : ((m == 2'd1) ? 2 : 4);
    endfunction

    function automatic logic [7:0] gen8(int n, int k, int a, int b, int c);
        logic [31:0] v;
        v = n * a + k * b + c;
        return v[7:0];
    endfunction

    // One pixel-clock step, called at each falling edge.
    task automatic step();
        int i;
        logic sel;
        string tag;
        i = tcyc % 16;
        if (e_v[i]) begin
            sel = (e_ps[i] == cfg_sel);
            chk("R7 select flag", sel_valid, sel);
            tag = !sel ? "R8 deselected colour" :
                  (e_bl[i] ? "R9 blanked colour" : "R4 slot order colour");
            chk(tag, pix_r, (sel && !e_bl[i]) ? e_r[i] : 0);
            chk(tag, pix_g, (sel && !e_bl[i]) ? e_g[i] : 0);
            chk(tag, pix_b, (sel && !e_bl[i]) ? e_b[i] : 0);
            chk("R9 blank flag", blank_out, e_bl[i]);
            chk("R10 sync gate", sync_out, e_sy[i] & cfg_sync_en);
            e_v[i] = 1'b0;
        end
        // R2 / R6: divider model
        chk("R2 R6 load strobe", load_out, m_cnt == 0);
        cfg_mux     = nx_mux;
        cfg_sel     = nx_sel;
        cfg_sync_en = nx_sync;
        if (!use_loop) man_load = man_req;
        if (use_loop ? (m_cnt == 0) : man_req) begin
            nload++;
            for (int k = 0; k < 4; k++) begin
                pr_in[k*8 +: 8]   = gen8(nload, k, 29, 71, 5);
                pg_in[k*8 +: 8]   = gen8(nload, k, 53, 17, 200);
                pb_in[k*8 +: 8]   = gen8(nload, k, 11, 97, 33);
                ps_in_v[k*2 +: 2] = 2'((nload + k + (nload >> 2)) % 4);
                bl_in[k]          = ((nload + k) % 6 == 5);
                sy_in[k]          = ((nload * 3 + k) % 4 == 1);
            end
            // R3 R4 R5: slots beyond the active ratio get no expectation
            for (int k = 0; k < nslots(m_act); k++) begin
                int j;
                j = (tcyc + 3 + k) % 16;
                e_r[j]  = pr_in[k*8 +: 8];
                e_g[j]  = pg_in[k*8 +: 8];
                e_b[j]  = pb_in[k*8 +: 8];
                e_ps[j] = ps_in_v[k*2 +: 2];
                e_bl[j] = bl_in[k];
                e_sy[j] = sy_in[k];
                e_v[j]  = 1'b1;
            end
        end
        if (m_cnt == nslots(m_act) - 1) begin
            m_cnt = 0;
            m_act = cfg_mux;
        end else begin
            m_cnt++;
        end
        tcyc++;
    endtask

    task automatic run(int c);
        for (int q = 0; q < c; q++) begin
            step();
            @(negedge clk);
        end
    endtask

    initial begin
        done = 1'b0;
        rst = 1'b1; cfg_mux = 2'd2; cfg_sel = 2'd1; cfg_sync_en = 1'b1;
        nx_mux = 2'd2; nx_sel = 2'd1; nx_sync = 1'b1;
        use_loop = 1'b1; man_load = 1'b0; man_req = 1'b0;
        pr_in = '1; pg_in = '1; pb_in = '1; ps_in_v = '0; bl_in = '0; sy_in = '1;
        for (int i = 0; i < 16; i++) e_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset red", pix_r, 0);
        chk("R1 reset green", pix_g, 0);
        chk("R1 reset blue", pix_b, 0);
        chk("R1 reset select", sel_valid, 0);
        chk("R1 reset blank", blank_out, 0);
        chk("R1 reset sync", sync_out, 0);
        m_cnt = 0; m_act = cfg_mux;
        rst = 1'b0;
        // Ratio sweep with select code and sync enable rotating.
        for (int seg = 0; seg < 12; seg++) begin
            case (seg)
                0, 1, 9, 11: nx_mux = 2'd2;
                2, 3, 7, 10: nx_mux = 2'd1;
                6:           nx_mux = 2'd3;
                default:     nx_mux = 2'd0;
            endcase
            nx_sel  = 2'(seg % 4);
            nx_sync = (seg % 3 != 0);
            run(61);
        end
        // R3: loads arriving before the word finishes restart at slot A.
        nx_mux = 2'd2;
        run(12);
        use_loop = 1'b0;
        for (int j = 0; j < 10; j++) begin
            man_req = 1'b1; run(1);
            man_req = 1'b0; run(j % 5 + 1);
        end
        run(8);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule